// File: doc/BRIEF.md
# Configurable-Phase SPI Shift Engine

This block moves one word (eight bits by default) over a four-wire serial link, most significant bit first, and can act either as the clock-driving end or as the clock-following end of that link. Three configuration inputs set the link's timing:
- a polarity input gives the level the serial clock rests at;
- an edge-select input says whether outgoing data changes when the clock leaves its resting level or when it returns to it;
- a sample-select input lets the clock-driving end capture incoming data halfway through each bit or at its very end.

In master mode, writing the transmit port starts a transfer at once. The serial clock's half-period is a programmable number of system clock cycles. In slave mode, the write only preloads the outgoing word. The external clock and chip select are brought through a synchronizer, and the engine always samples halfway through each bit, whatever the sample-select input says.

A completed word lands in a receive buffer and raises a full flag. A read strobe clears that flag. A word that completes while the flag is still up is dropped and sets a sticky overflow flag. A write that arrives while a transfer is running is dropped and sets a sticky collision flag. Both sticky flags clear only on reset.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `buf_full`, `overflow`, `wcol` and `busy` are 0, `rx_data` is 0, and `sck_o` equals `cfg_idle_hi`.
- R2: In master mode a transfer lasts 2*DATA_W half-periods (numbered h = 0 upward), each lasting `cfg_div` system clocks. During half h, `sck_o` = `cfg_idle_hi` XOR (`cfg_shift_on_trail` ? h[0] : NOT h[0]). Outside a transfer, `sck_o` rests at `cfg_idle_hi`.
- R3: In master mode `mosi_o` carries bit DATA_W-1-k of the written word during halves 2k and 2k+1. The first bit appears in the cycle after the write.
- R4: In master mode, with `cfg_late_sample`=0 the engine captures `miso_i` at the last clock of each even half. With `cfg_late_sample`=1 it captures at the last clock of each odd half.
- R5: In slave mode, while `cs_n_i` is low, the engine captures `mosi_i` on the clock edge that does not change outgoing data. `cfg_late_sample` has no effect in this mode.
- R6: In slave mode `miso_o` shows the MSB of the preloaded word as soon as `cs_n_i` is low. It moves to the next bit on each active-to-idle clock edge (`cfg_shift_on_trail`=1), or on each idle-to-active edge after the first (`cfg_shift_on_trail`=0). It is 0 while `cs_n_i` is high.
- R7: A completed word is copied to `rx_data` and sets `buf_full`. A one-cycle `rx_rd` pulse clears `buf_full`.
- R8: A word that completes while `buf_full` is 1 and no read is in the same cycle leaves `rx_data` unchanged and sets `overflow`, which stays 1 until reset.
- R9: A `tx_wr` while `busy` is 1 sets `wcol`, which stays 1 until reset, and does not change the bits being sent.
- R10: In master mode `busy` is 1 from the cycle after the write until the received word is loaded, and is 0 from the following cycle.
- R11: A `cfg_div` of 0 gives the same one-system-clock half-period as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = drive the serial clock, 0 = follow it |
| cfg_idle_hi | input | 1 | Resting level of the serial clock |
| cfg_shift_on_trail | input | 1 | 1 = data changes on active-to-idle edge, 0 = on idle-to-active edge |
| cfg_late_sample | input | 1 | Master only: 1 = capture at end of bit, 0 = mid-bit |
| cfg_div | input | DIV_W | Master half-period in system clocks (0 acts as 1) |
| tx_wr | input | 1 | Write strobe for the outgoing word |
| tx_data | input | DATA_W | Outgoing word |
| rx_rd | input | 1 | Read strobe, clears the full flag |
| rx_data | output | DATA_W | Last accepted received word |
| buf_full | output | 1 | Receive buffer holds an unread word |
| overflow | output | 1 | Sticky: a word was dropped because the buffer was full |
| wcol | output | 1 | Sticky: a write arrived during a transfer |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in, master mode |
| sck_i | input | 1 | Serial clock in, slave mode |
| cs_n_i | input | 1 | Active-low chip select, slave mode |
| mosi_i | input | 1 | Serial data in, slave mode |
| miso_o | output | 1 | Serial data out, slave mode |

## Verification
The hardest case to reach from the ports is telling mid-bit capture apart from end-of-bit capture. A well-behaved partner holds its data for the whole bit, so both capture points give the same word. The bench therefore plays a partner that drives one word during the first half of every bit and a different word during the second half. Because only the capture point decides which of the two words arrives, that choice becomes visible in `rx_data`. This is swept over every polarity, edge-select and sample-select setting and over several divider values.

// File: rtl/spi_eng_pkg.sv
// Shared constants and helpers for the SPI shift engine.
// Assumes the word width is a power of two so that bit counters wrap cleanly.
package spi_eng_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_DIV_W  = 8;
    localparam int SYNC_DEPTH = 2;

    // Serial clock level during a given half-period of a master transfer.
    // Halves alternate; shift_on_trail picks which parity holds the active level.
    function automatic logic sck_level(input logic idle_hi,
                                       input logic shift_on_trail,
                                       input logic odd_half);
        return idle_hi ^ (shift_on_trail ? odd_half : ~odd_half);
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes each bit is independent; the reset value is a parameter so that
// active-low selects can come out of reset inactive.
module spi_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop takes the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= d;
            end
        end else begin : g_next
            // Later flops take the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= RST_VAL;
                else        stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_master_seq.sv
// Master timing sequencer: divides the system clock into half-periods and
// walks through 2*DATA_W of them per transfer.
// tick marks the last system clock of a half; fin pulses one cycle after the
// final tick. Assumes start is only raised while idle.
module spi_master_seq #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    output logic             active,
    output logic             half_odd,
    output logic             tick,
    output logic             fin
);

    localparam int HALVES = 2 * DATA_W;
    localparam int HC_W   = $clog2(HALVES);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_div;
    logic [HC_W-1:0]  half;
    logic             last_half;

    // A divider of zero is treated as one.
    assign eff_div   = (div == '0) ? DIV_W'(1) : div;
    assign tick      = active && (cnt == eff_div - DIV_W'(1));
    assign last_half = (half == HC_W'(HALVES - 1));
    assign half_odd  = half[0];

    // Half-period and divider counters, transfer activity and finish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            half   <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= tick && last_half;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                half   <= '0;
            end else if (tick) begin
                cnt <= '0;
                if (last_half) active <= 1'b0;
                else           half   <= half + HC_W'(1);
            end else if (active) begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_slave_seq.sv
// Slave timing sequencer: finds edges of the synchronized external clock
// while selected and classifies them as sample or shift edges.
// Assumes sck, select and data have been through synchronizers of equal depth.
// The first idle-to-active edge of a word does not shift when data changes on
// that edge, because the MSB is already on the line.
module spi_slave_seq #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic sel_s,
    input  logic idle_hi,
    input  logic shift_on_trail,
    output logic sample_ev,
    output logic shift_ev,
    output logic done,
    output logic busy
);

    localparam int CNT_W = $clog2(DATA_W);

    logic             sck_d;
    logic             lead_ev;
    logic             trail_ev;
    logic             change_ev;
    logic [CNT_W-1:0] bit_cnt;
    logic             last_bit;

    assign lead_ev   = sel_s && (sck_d == idle_hi) && (sck_s != idle_hi);
    assign trail_ev  = sel_s && (sck_d != idle_hi) && (sck_s == idle_hi);
    assign sample_ev = shift_on_trail ? lead_ev : trail_ev;
    assign change_ev = shift_on_trail ? trail_ev : lead_ev;
    assign shift_ev  = change_ev && (shift_on_trail || (bit_cnt != '0));
    assign last_bit  = (bit_cnt == CNT_W'(DATA_W - 1));
    assign busy      = sel_s && (bit_cnt != '0);

    // Edge history, bit counting and end-of-word pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            bit_cnt <= '0;
            done    <= 1'b0;
        end else begin
            sck_d <= sck_s;
            done  <= sample_ev && last_bit;
            if (!sel_s)         bit_cnt <= '0;
            else if (sample_ev) bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_shift_core.sv
// Transmit and receive shift registers, MSB first.
// Assumes load and shift_tx never coincide (load is only taken while idle).
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_tx,
    input  logic              sample,
    input  logic              din,
    output logic              tx_msb,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;

    // Outgoing register: load a word or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sr <= '0;
        else if (load)     tx_sr <= load_val;
        else if (shift_tx) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end

    // Incoming register: append each captured bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_sr <= '0;
        else if (sample) rx_sr <= {rx_sr[DATA_W-2:0], din};
    end

    assign tx_msb  = tx_sr[DATA_W-1];
    assign rx_word = rx_sr;

endmodule

// File: rtl/spi_rx_buf.sv
// Receive holding buffer with full flag and sticky overflow.
// A completion and a read in the same cycle count as the old word consumed
// and the new one stored.
module spi_rx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] word,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              ovf
);

    // Buffer load, full-flag update and overflow capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            full  <= 1'b0;
            ovf   <= 1'b0;
        end else if (done) begin
            if (full && !rd) begin
                ovf <= 1'b1;
            end else begin
                rdata <= word;
                full  <= 1'b1;
            end
        end else if (rd) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
// Configurable-phase SPI shift engine, master or slave, one word per transfer.
// Master mode: a write starts a transfer clocked by the internal divider.
// Slave mode: a write preloads the outgoing word; the external clock, select
// and data are synchronized and the engine always samples mid-bit.
// Assumes configuration inputs are held steady during a transfer.
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int DIV_W  = DEF_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_idle_hi,
    input  logic              cfg_shift_on_trail,
    input  logic              cfg_late_sample,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              overflow,
    output logic              wcol,
    output logic              busy,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              miso_o
);

    // Synchronized slave-side inputs: {sck, cs_n, mosi}.
    logic [2:0] ext_s;
    logic       sck_s;
    logic       sel_s;
    logic       mosi_s;

    logic m_active, m_odd, m_tick, m_fin, m_busy, m_start;
    logic s_sample, s_shift, s_done, s_busy;
    logic wr_ok;
    logic sample, shift_tx, din, done_any, tx_msb;
    logic [DATA_W-1:0] rx_word;

    spi_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck_i, cs_n_i, mosi_i}),
        .q    (ext_s)
    );

    assign sck_s  = ext_s[2];
    assign sel_s  = ~ext_s[1] & ~cfg_master;
    assign mosi_s = ext_s[0];

    spi_master_seq #(
        .DATA_W(DATA_W),
        .DIV_W (DIV_W)
    ) u_mseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (m_start),
        .div     (cfg_div),
        .active  (m_active),
        .half_odd(m_odd),
        .tick    (m_tick),
        .fin     (m_fin)
    );

    spi_slave_seq #(
        .DATA_W(DATA_W)
    ) u_sseq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_s         (sck_s),
        .sel_s         (sel_s),
        .idle_hi       (cfg_idle_hi),
        .shift_on_trail(cfg_shift_on_trail),
        .sample_ev     (s_sample),
        .shift_ev      (s_shift),
        .done          (s_done),
        .busy          (s_busy)
    );

    assign m_busy  = m_active | m_fin;
    assign busy    = cfg_master ? m_busy : s_busy;
    assign wr_ok   = tx_wr & ~busy;
    assign m_start = wr_ok & cfg_master;

    // Master captures mid-bit (end of even half) or end-of-bit (end of odd half).
    assign sample   = cfg_master ? (m_tick & (cfg_late_sample ? m_odd : ~m_odd)) : s_sample;
    assign shift_tx = cfg_master ? (m_tick & m_odd) : s_shift;
    assign din      = cfg_master ? miso_i : mosi_s;
    assign done_any = cfg_master ? m_fin : s_done;

    spi_shift_core #(
        .DATA_W(DATA_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_ok),
        .load_val(tx_data),
        .shift_tx(shift_tx),
        .sample  (sample),
        .din     (din),
        .tx_msb  (tx_msb),
        .rx_word (rx_word)
    );

    spi_rx_buf #(
        .DATA_W(DATA_W)
    ) u_rxbuf (
        .clk  (clk),
        .rst_n(rst_n),
        .done (done_any),
        .word (rx_word),
        .rd   (rx_rd),
        .rdata(rx_data),
        .full (buf_full),
        .ovf  (overflow)
    );

    // Sticky write-collision flag.
    always_ff @(posedge clk) begin
        if (!rst_n)            wcol <= 1'b0;
        else if (tx_wr && busy) wcol <= 1'b1;
    end

    assign sck_o  = (cfg_master && m_active)
                  ? sck_level(cfg_idle_hi, cfg_shift_on_trail, m_odd)
                  : cfg_idle_hi;
    assign mosi_o = cfg_master & tx_msb;
    assign miso_o = ~cfg_master & ~cs_n_i & tx_msb;

endmodule

// File: rtl/spi_shift_engine_chk.sv
// Property checker for the SPI shift engine, attached with bind.
module spi_shift_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_idle_hi,
    input logic              tx_wr,
    input logic              rx_rd,
    input logic              busy,
    input logic              buf_full,
    input logic              overflow,
    input logic              wcol,
    input logic              sck_o,
    input logic              byte_done,
    input logic [DATA_W-1:0] rx_data
);

    AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == cfg_idle_hi)); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !byte_done) |=> !buf_full); // R7

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(rx_data)); // R7

    AST_OVF_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (buf_full && $stable(rx_data))); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8

    AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && busy) |=> wcol); // R9

    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wcol |=> wcol); // R9

endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_idle_hi(cfg_idle_hi),
    .tx_wr      (tx_wr),
    .rx_rd      (rx_rd),
    .busy       (busy),
    .buf_full   (buf_full),
    .overflow   (overflow),
    .wcol       (wcol),
    .sck_o      (sck_o),
    .byte_done  (done_any),
    .rx_data    (rx_data)
);

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;

    localparam int DW = 8;
    localparam int VW = 8;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_master = 1'b0, cfg_idle_hi = 1'b0, cfg_shift_on_trail = 1'b0, cfg_late_sample = 1'b0;
    logic [VW-1:0] cfg_div = '0;
    logic          tx_wr = 1'b0, rx_rd = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [DW-1:0] rx_data;
    logic          buf_full, overflow, wcol, busy, sck_o, mosi_o, miso_o;
    logic          miso_i = 1'b0, sck_i = 1'b0, cs_n_i = 1'b1, mosi_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_shift_engine #(.DATA_W(DW), .DIV_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_idle_hi(cfg_idle_hi),
        .cfg_shift_on_trail(cfg_shift_on_trail), .cfg_late_sample(cfg_late_sample),
        .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .buf_full(buf_full), .overflow(overflow), .wcol(wcol),
        .busy(busy), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
        .cs_n_i(cs_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Read the receive buffer and confirm the full flag drops (R7).
    task automatic read_buf();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
        chk(buf_full == 1'b0, "R7 read clears full", int'(buf_full), 0);
    endtask

    // Master transfer. The partner drives word a during even halves and word b
    // during odd halves, so the captured word reveals the sample point (R4).
    task automatic master_xfer(input bit pol, input bit trail, input bit late,
                               input logic [VW-1:0] div, input logic [DW-1:0] t,
                               input logic [DW-1:0] a, input logic [DW-1:0] b,
                               input bit inject, input bit check_rx, input string tag);
        int ediv;
        int sck_bad;
        int mosi_bad;
        logic [DW-1:0] exp_rx;
        ediv = (div == 0) ? 1 : int'(div);
        sck_bad = 0; mosi_bad = 0;
        exp_rx = late ? b : a;
        @(negedge clk);
        cfg_master = 1'b1; cfg_idle_hi = pol; cfg_shift_on_trail = trail;
        cfg_late_sample = late; cfg_div = div;
        @(negedge clk);
        chk(sck_o == pol, {tag, " R2 idle level before start"}, int'(sck_o), int'(pol));
        tx_data = t; tx_wr = 1'b1;
        @(posedge clk);
        for (int h = 0; h < 2*DW; h++) begin
            logic exp_sck;
            @(negedge clk);
            tx_wr = 1'b0;
            if (inject && h == 6) begin
                tx_wr = 1'b1; tx_data = ~t;
            end
            miso_i = h[0] ? b[DW-1-h/2] : a[DW-1-h/2];
            exp_sck = pol ^ (trail ? h[0] : ~h[0]);
            if (sck_o !== exp_sck) sck_bad++;
            if (mosi_o !== t[DW-1-h/2]) mosi_bad++;
            if (h == 0) chk(busy == 1'b1, {tag, " R10 busy after write"}, int'(busy), 1);
            repeat (ediv) @(posedge clk);
        end
        tx_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(sck_bad == 0, {tag, " R2 sck waveform mismatches"}, sck_bad, 0);
        chk(mosi_bad == 0, {tag, " R3 mosi bit mismatches"}, mosi_bad, 0);
        chk(busy == 1'b0, {tag, " R10 busy cleared"}, int'(busy), 0);
        if (check_rx) begin
            chk(buf_full == 1'b1, {tag, " R7 full after word"}, int'(buf_full), 1);
            chk(rx_data == exp_rx, {tag, " R4 captured word"}, int'(rx_data), int'(exp_rx));
        end
    endtask

    // Slave transfer: the bench drives the clock, select and data (R5, R6).
    task automatic slave_xfer(input bit pol, input bit trail, input bit late,
                              input logic [DW-1:0] t, input logic [DW-1:0] m);
        int miso_bad;
        miso_bad = 0;
        @(negedge clk);
        cfg_master = 1'b0; cfg_idle_hi = pol; cfg_shift_on_trail = trail;
        cfg_late_sample = late; sck_i = pol; cs_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(miso_o == 1'b0, "R6 miso low while deselected", int'(miso_o), 0);
        tx_data = t; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        cs_n_i = 1'b0;
        for (int k = 0; k < DW; k++) begin
            if (trail) begin
                mosi_i = m[DW-1-k];
                repeat (H) @(negedge clk);
                if (miso_o !== t[DW-1-k]) miso_bad++;
                sck_i = ~pol;
                repeat (H) @(negedge clk);
                sck_i = pol;
            end else begin
                sck_i = ~pol;
                mosi_i = m[DW-1-k];
                repeat (H) @(negedge clk);
                if (miso_o !== t[DW-1-k]) miso_bad++;
                sck_i = pol;
                repeat (H) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        cs_n_i = 1'b1;
        chk(miso_bad == 0, "R6 slave miso bit mismatches", miso_bad, 0);
        chk(buf_full == 1'b1, "R7 slave full after word", int'(buf_full), 1);
        chk(rx_data == m, "R5 slave captured word", int'(rx_data), int'(m));
        read_buf();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int idx;
        do_reset();
        @(negedge clk);
        chk(buf_full == 0 && overflow == 0 && wcol == 0 && busy == 0, "R1 flags after reset",
            int'({buf_full, overflow, wcol, busy}), 0);
        chk(rx_data == '0, "R1 rx_data after reset", int'(rx_data), 0);
        chk(sck_o == 1'b0, "R1 sck idle after reset", int'(sck_o), 0);

        // Master sweep over polarity, edge select, sample point and divider.
        idx = 0;
        for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++)
                for (int s = 0; s < 2; s++)
                    for (int d = 1; d <= 3; d++) begin
                        logic [DW-1:0] t, a, b;
                        t = DW'(8'hA5 ^ (idx * 37));
                        a = DW'(idx * 29 + 3);
                        b = ~a ^ DW'(idx);
                        master_xfer(p[0], e[0], s[0], VW'(d), t, a, b, 1'b0, 1'b1, "master");
                        read_buf();
                        idx++;
                    end

        // Zero divider behaves as one (R11).
        master_xfer(1'b0, 1'b1, 1'b0, '0, 8'h3C, 8'h96, 8'h69, 1'b0, 1'b1, "R11 div0");
        read_buf();

        // Slave sweep; the sample-select input must not matter (R5).
        idx = 0;
        for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++)
                for (int s = 0; s < 2; s++) begin
                    slave_xfer(p[0], e[0], s[0], DW'(8'h5B + idx * 41), DW'(8'hC3 ^ (idx * 23)));
                    idx++;
                end

        // Write during a master transfer is flagged and ignored (R9).
        master_xfer(1'b1, 1'b0, 1'b1, 8'd2, 8'hE1, 8'h0F, 8'hB4, 1'b1, 1'b1, "R9 collision");
        chk(wcol == 1'b1, "R9 wcol set", int'(wcol), 1);
        read_buf();
        chk(wcol == 1'b1, "R9 wcol sticky", int'(wcol), 1);

        // Second word without a read: dropped and flagged (R8).
        do_reset();
        master_xfer(1'b0, 1'b0, 1'b0, 8'd1, 8'h11, 8'h77, 8'h88, 1'b0, 1'b1, "R8 first");
        chk(overflow == 1'b0, "R8 no overflow yet", int'(overflow), 0);
        master_xfer(1'b0, 1'b0, 1'b0, 8'd1, 8'h22, 8'h44, 8'h99, 1'b0, 1'b0, "R8 second");
        chk(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
        chk(rx_data == 8'h77, "R8 buffer kept", int'(rx_data), 8'h77);
        chk(buf_full == 1'b1, "R8 still full", int'(buf_full), 1);
        read_buf();
        chk(overflow == 1'b1, "R8 overflow sticky", int'(overflow), 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule